// File: doc/BRIEF.md
# Gap-Sync Serial Read Deserializer

This block sits between a rotating-media bit source and a host register interface. It turns a serial bit stream into bytes. Each accepted bit-slot strobe carries one bit, and bits arrive least significant first. Once the host arms a gap search, the block drops the run of zero bits that pads the gap between records. It treats the first 1 as a sync mark. It then packs the following bits into bytes. A 16-bit reflected CRC runs over the sync mark and every data bit.

Each finished byte is copied into a host-visible holding register. The block then raises a byte-ready flag and, if enabled, an interrupt. The host reads the holding register and a status byte. The status byte shows the flag and whether the CRC residue is nonzero. To validate a record, software sets the CRC-phase control bit before the two CRC bytes arrive. Once those bytes have been read, a zero residue means the record is intact.

The bit stream uses a valid/ready handshake. The block never applies back-pressure, so `bit_ready` is held at 1 and every `bit_valid` cycle is a consumed slot. A slot whose bit is not needed (write mode, or transfer reset active) is still consumed and simply dropped. The producer must therefore not hold a bit back waiting for ready. Control and host strobes are plain single-cycle pulses.

Top module: `disk_read_deser`

## Requirements
- R1: Data bits fill byte positions 0 to 7 in arrival order (first bit is bit 0). On the slot that carries the eighth data bit, the assembled byte appears on `data_q` one clock later.
- R2: A control write whose bit 6 is 1 arms the gap search only if the previously written bit 6 was 0. Rewriting bit 6 as 1 while it is already 1 does not re-arm.
- R3: While armed and with CRC phase (control bit 4) clear, zero bits are discarded. The first 1 disarms the search, restarts the byte at position 0, and is not stored as data.
- R4: The CRC is 16 bits wide and shifts right once per bit. When its LSB XOR the incoming bit is 1, the shifted value is XORed with 0x8408. The sync 1 is the first bit fed, starting from 0. Status bit 4 is 1 exactly when the CRC is nonzero, and it reads 0 after a record's CRC low byte then high byte have been received.
- R5: When a byte completes, status bit 1 (byte-ready flag) becomes 1. `irq` becomes 1 if control bit 7 is 1.
- R6: While CRC phase is set, zero bits are taken as data even when armed. CRC phase clears by itself when a byte completes, after which an armed search resumes discarding zeros.
- R7: A status read strobe or a data read strobe clears both the flag and `irq`.
- R8: Any control write clears `irq` and leaves the flag unchanged.
- R9: Slots are ignored (no byte progress, no CRC change) while control bit 2 is 0 (write mode) or `xfer_rst` is 1.
- R10: After reset `data_q`, `status` and `irq` are 0, and `bit_ready` is 1.
- R11: When a byte completes in the same cycle as a read strobe, the flag and interrupt are set rather than cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_valid | input | 1 | Bit-slot strobe |
| bit_data | input | 1 | Bit carried by the slot |
| bit_ready | output | 1 | Always 1; the block never stalls the stream |
| xfer_rst | input | 1 | Transfer reset; 1 blocks slot processing |
| ctrl_wr | input | 1 | Control register write strobe |
| ctrl_data | input | 8 | Control value: bit 2 read mode, bit 4 CRC phase, bit 6 arm, bit 7 interrupt enable |
| stat_rd | input | 1 | Status register read strobe |
| data_rd | input | 1 | Data register read strobe |
| data_q | output | 8 | Last completed byte |
| status | output | 8 | Bit 1 byte-ready flag, bit 4 CRC nonzero, others 0 |
| irq | output | 1 | Byte-ready interrupt |

## Verification
The assertions check several rules on every cycle. An interrupt never stands without the flag. A read with no completing byte leaves the flag clear. A sync hit seeds the CRC with 0x8408. The bit index resets after a byte, and it holds on discarded or ignored slots. The bench scenarios are needed to show the rest: LSB-first assembly of real values, arm-edge detection against a rewrite, CRC phase clearing itself, ignored slots in write mode and under transfer reset, and a zero residue after a full record with its CRC bytes.

// File: rtl/dr_pkg.sv
`timescale 1ns/1ps
package dr_pkg;
  localparam int CTRL_W    = 8;
  localparam int MODE_BIT  = 2;
  localparam int CRCPH_BIT = 4;
  localparam int ARM_BIT   = 6;
  localparam int IEN_BIT   = 7;
  localparam int STAT_FLAG = 1;
  localparam int STAT_CRC  = 4;

  function automatic logic [15:0] crc_step16(input logic [15:0] c, input logic b,
                                             input logic [15:0] poly);
    logic [15:0] s;
    s = c >> 1;
    if (c[0] ^ b) s = s ^ poly;
    return s;
  endfunction
endpackage

// File: rtl/dr_ctrl.sv
`timescale 1ns/1ps
module dr_ctrl
  import dr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_wr,
  input  logic [CTRL_W-1:0] ctrl_data,
  input  logic              sync_hit,
  input  logic              byte_done,
  output logic              mode_rd,
  output logic              crc_phase,
  output logic              irq_en,
  output logic              armed
);
  logic arm_lvl_q;
  logic arm_edge;

  assign arm_edge = ctrl_wr && !arm_lvl_q && ctrl_data[ARM_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_rd   <= 1'b0;
      irq_en    <= 1'b0;
      arm_lvl_q <= 1'b0;
      crc_phase <= 1'b0;
      armed     <= 1'b0;
    end else begin
      if (ctrl_wr) begin
        mode_rd   <= ctrl_data[MODE_BIT];
        irq_en    <= ctrl_data[IEN_BIT];
        arm_lvl_q <= ctrl_data[ARM_BIT];
        crc_phase <= ctrl_data[CRCPH_BIT];
      end else if (byte_done) begin
        crc_phase <= 1'b0;
      end
      if (arm_edge)      armed <= 1'b1;
      else if (sync_hit) armed <= 1'b0;
    end
  end

  // R6: a byte completing with no control write leaves CRC phase clear
  a_r6_phase_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && !ctrl_wr) |=> !crc_phase);
  // R2: rewriting the arm bit while already high does not arm a disarmed search
  a_r2_no_rearm: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && arm_lvl_q && !armed && !sync_hit) |=> !armed);
endmodule

// File: rtl/dr_shift.sv
`timescale 1ns/1ps
module dr_shift #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              bit_in,
  input  logic              hunt,
  output logic              sync_hit,
  output logic              data_en,
  output logic              byte_done,
  output logic [DATA_W-1:0] byte_val
);
  localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(DATA_W - 1);

  logic [IDX_W-1:0]  idx_q;
  logic [DATA_W-1:0] sh_q;

  assign sync_hit  = take && hunt && bit_in;
  assign data_en   = take && !hunt;
  assign byte_done = data_en && (idx_q == LAST);

  always_comb begin
    byte_val = sh_q;
    byte_val[idx_q] = bit_in;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q <= '0;
      sh_q  <= '0;
    end else if (sync_hit) begin
      idx_q <= '0;
    end else if (data_en) begin
      sh_q[idx_q] <= bit_in;
      idx_q       <= byte_done ? '0 : idx_q + 1'b1;
    end
  end

  // R1: after a completed byte the next data bit lands in position 0
  a_r1_idx_wraps: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |=> (idx_q == '0));
  // R3: a discarded gap zero does not advance the byte position
  a_r3_gap_zero_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (take && hunt && !bit_in) |=> $stable(idx_q));
  // R9: without an accepted slot the byte position holds
  a_r9_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(idx_q));
endmodule

// File: rtl/dr_crc.sv
`timescale 1ns/1ps
module dr_crc
  import dr_pkg::*;
#(
  parameter logic [15:0] POLY = 16'h8408
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        seed,
  input  logic        step,
  input  logic        bit_in,
  output logic        nonzero,
  output logic [15:0] crc_q
);
  assign nonzero = |crc_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     crc_q <= '0;
    else if (seed)  crc_q <= crc_step16(16'h0000, 1'b1, POLY);
    else if (step)  crc_q <= crc_step16(crc_q, bit_in, POLY);
  end

  // R4: the sync mark restarts the CRC from zero with a single 1 bit
  a_r4_seed_value: assert property (@(posedge clk) disable iff (!rst_n)
    seed |=> (crc_q == POLY));
  // R9: no slot, no CRC change
  a_r9_crc_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!seed && !step) |=> $stable(crc_q));
endmodule

// File: rtl/dr_host.sv
`timescale 1ns/1ps
module dr_host
  import dr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_done,
  input  logic [DATA_W-1:0] byte_val,
  input  logic              irq_en,
  input  logic              crc_nz,
  input  logic              stat_rd,
  input  logic              data_rd,
  input  logic              ctrl_wr,
  output logic [DATA_W-1:0] data_q,
  output logic [7:0]        status,
  output logic              irq
);
  logic flag_q;

  generate
    for (genvar i = 0; i < 8; i++) begin : g_stat
      if (i == STAT_FLAG) begin : g_f
        assign status[i] = flag_q;
      end else if (i == STAT_CRC) begin : g_c
        assign status[i] = crc_nz;
      end else begin : g_z
        assign status[i] = 1'b0;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q <= '0;
      flag_q <= 1'b0;
      irq    <= 1'b0;
    end else begin
      if (byte_done) data_q <= byte_val;
      if (byte_done)                 flag_q <= 1'b1;
      else if (stat_rd || data_rd)   flag_q <= 1'b0;
      if (byte_done && irq_en)                 irq <= 1'b1;
      else if (stat_rd || data_rd || ctrl_wr)  irq <= 1'b0;
    end
  end

  // R5: an interrupt never stands without the byte-ready flag
  a_r5_irq_implies_flag: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> flag_q);
  // R7: a read with no completing byte leaves the flag and interrupt clear
  a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat_rd || data_rd) && !byte_done) |=> (!flag_q && !irq));
  // R11: a completing byte wins over a simultaneous read
  a_r11_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |=> flag_q);
  // R8: a control write alone does not disturb the flag
  a_r8_flag_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && !byte_done && !stat_rd && !data_rd) |=> $stable(flag_q));
endmodule

// File: rtl/disk_read_deser.sv
`timescale 1ns/1ps
module disk_read_deser
  import dr_pkg::*;
#(
  parameter int          DATA_W   = 8,
  parameter logic [15:0] CRC_POLY = 16'h8408
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_valid,
  input  logic              bit_data,
  output logic              bit_ready,
  input  logic              xfer_rst,
  input  logic              ctrl_wr,
  input  logic [CTRL_W-1:0] ctrl_data,
  input  logic              stat_rd,
  input  logic              data_rd,
  output logic [DATA_W-1:0] data_q,
  output logic [7:0]        status,
  output logic              irq
);
  logic mode_rd, crc_phase, irq_en, armed;
  logic take, hunt, sync_hit, data_en, byte_done, crc_nz;
  logic [DATA_W-1:0] byte_val;
  logic [15:0] crc_val;

  assign bit_ready = 1'b1;
  assign take      = bit_valid && mode_rd && !xfer_rst;
  assign hunt      = armed && !crc_phase;

  dr_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_data(ctrl_data),
    .sync_hit(sync_hit), .byte_done(byte_done), .mode_rd(mode_rd),
    .crc_phase(crc_phase), .irq_en(irq_en), .armed(armed)
  );

  dr_shift #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .take(take), .bit_in(bit_data), .hunt(hunt),
    .sync_hit(sync_hit), .data_en(data_en), .byte_done(byte_done),
    .byte_val(byte_val)
  );

  dr_crc #(.POLY(CRC_POLY)) u_crc (
    .clk(clk), .rst_n(rst_n), .seed(sync_hit), .step(data_en),
    .bit_in(bit_data), .nonzero(crc_nz), .crc_q(crc_val)
  );

  dr_host #(.DATA_W(DATA_W)) u_host (
    .clk(clk), .rst_n(rst_n), .byte_done(byte_done), .byte_val(byte_val),
    .irq_en(irq_en), .crc_nz(crc_nz), .stat_rd(stat_rd), .data_rd(data_rd),
    .ctrl_wr(ctrl_wr), .data_q(data_q), .status(status), .irq(irq)
  );

  // R4: status bit for CRC tracks the residue register
  a_r4_crc_flag: assert property (@(posedge clk) disable iff (!rst_n)
    status[STAT_CRC] == (crc_val != 16'h0000));
  // R9: slots in write mode or under transfer reset never complete a byte
  a_r9_no_byte_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_rd || xfer_rst) |-> !byte_done);
endmodule

// File: tb/disk_read_deser_test.sv
`timescale 1ns/1ps
module disk_read_deser_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_valid = 1'b0, bit_data = 1'b0, xfer_rst = 1'b0;
  logic ctrl_wr = 1'b0, stat_rd = 1'b0, data_rd = 1'b0;
  logic [7:0] ctrl_data = 8'h00;
  logic bit_ready, irq;
  logic [7:0] data_q, status;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [15:0] mc;

  always #4 clk = ~clk;

  disk_read_deser uut (
    .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .bit_data(bit_data),
    .bit_ready(bit_ready), .xfer_rst(xfer_rst), .ctrl_wr(ctrl_wr),
    .ctrl_data(ctrl_data), .stat_rd(stat_rd), .data_rd(data_rd),
    .data_q(data_q), .status(status), .irq(irq)
  );

  // gap length, byte value, interrupt enable
  localparam logic [12:0] VEC [0:5] = '{
    {4'd3, 8'hA5, 1'b1}, {4'd0, 8'h01, 1'b0}, {4'd7, 8'h80, 1'b1},
    {4'd1, 8'hFF, 1'b0}, {4'd5, 8'h3C, 1'b1}, {4'd2, 8'h00, 1'b0}
  };

  function automatic logic [15:0] mstep(input logic [15:0] c, input logic b);
    return (c[0] ^ b) ? ((c >> 1) ^ 16'h8408) : (c >> 1);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [15:0] act,
                     input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wctl(input logic [7:0] v);
    @(negedge clk); ctrl_wr = 1'b1; ctrl_data = v;
    @(negedge clk); ctrl_wr = 1'b0;
  endtask

  task automatic sbit(input logic b);
    @(negedge clk); bit_valid = 1'b1; bit_data = b;
    @(negedge clk); bit_valid = 1'b0;
  endtask

  task automatic sbyte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) begin
      sbit(v[i]);
      mc = mstep(mc, v[i]);
    end
  endtask

  task automatic rstat(output logic [7:0] s);
    s = status;
    @(negedge clk); stat_rd = 1'b1;
    @(negedge clk); stat_rd = 1'b0;
  endtask

  task automatic rdata();
    @(negedge clk); data_rd = 1'b1;
    @(negedge clk); data_rd = 1'b0;
  endtask

  task automatic arm(input logic [7:0] extra);
    wctl(8'h04 | extra);
    wctl(8'h44 | extra);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] s;
    logic [15:0] crc_rec;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk(data_q == 8'h00, "R10 data_q", {8'h0, data_q}, 16'h0);
    chk(status == 8'h00, "R10 status", {8'h0, status}, 16'h0);
    chk(irq == 1'b0 && bit_ready == 1'b1, "R10 irq/ready", {14'h0, irq, bit_ready}, 16'h1);

    // table walk: R1 R3 R4 R5 R7
    foreach (VEC[k]) begin
      logic [3:0] gap; logic [7:0] val; logic ien;
      {gap, val, ien} = VEC[k];
      arm({ien, 7'h0});
      for (int g = 0; g < gap; g++) sbit(1'b0);
      sbit(1'b1);
      mc = mstep(16'h0, 1'b1);
      sbyte(val);
      chk(data_q == val, "R1 R3 byte value", {8'h0, data_q}, {8'h0, val});
      chk(irq == ien, "R5 irq", {15'h0, irq}, {15'h0, ien});
      rstat(s);
      chk(s[1] == 1'b1, "R5 flag", {8'h0, s}, 16'h0002);
      chk(s[4] == (mc != 0), "R4 crc nonzero bit", {8'h0, s}, mc);
      chk(status[1] == 1'b0 && irq == 1'b0, "R7 status read clears",
          {14'h0, status[1], irq}, 16'h0);
    end

    // R2: rewriting bit 6 high does not re-arm
    arm(8'h00);
    sbit(1'b1);
    sbyte(8'h3C);
    rstat(s);
    wctl(8'h44);
    sbyte(8'h00);
    chk(status[1] == 1'b1 && data_q == 8'h00, "R2 no rearm", {status, data_q}, 16'h0200);

    // R6: CRC phase takes zeros as data, then clears
    wctl(8'h04);
    wctl(8'h54);
    sbyte(8'h10);
    chk(data_q == 8'h10, "R6 zeros taken in crc phase", {8'h0, data_q}, 16'h0010);
    rstat(s);
    sbit(1'b0); sbit(1'b0); sbit(1'b1);
    sbyte(8'h81);
    chk(data_q == 8'h81, "R6 hunting resumes", {8'h0, data_q}, 16'h0081);
    rstat(s);

    // R9: write mode and transfer reset ignore slots
    arm(8'h00);
    sbit(1'b1);
    sbit(1'b0); sbit(1'b1); sbit(1'b1); sbit(1'b0);
    wctl(8'h40);
    for (int i = 0; i < 8; i++) sbit(1'b1);
    chk(status[1] == 1'b0, "R9 write mode no byte", {15'h0, status[1]}, 16'h0);
    wctl(8'h44);
    xfer_rst = 1'b1;
    for (int i = 0; i < 8; i++) sbit(1'b1);
    xfer_rst = 1'b0;
    sbit(1'b1); sbit(1'b0); sbit(1'b0); sbit(1'b1);
    chk(data_q == 8'h96, "R9 ignored slots", {8'h0, data_q}, 16'h0096);
    rstat(s);

    // R4: full record with appended CRC leaves zero residue
    arm(8'h00);
    sbit(1'b0); sbit(1'b0); sbit(1'b1);
    mc = mstep(16'h0, 1'b1);
    sbyte(8'h12); rdata();
    sbyte(8'h34); rdata();
    chk(status[4] == (mc != 0), "R4 residue before crc", {15'h0, status[4]}, mc);
    crc_rec = mc;
    wctl(8'h54);
    sbyte(crc_rec[7:0]); rdata();
    sbyte(crc_rec[15:8]);
    chk(data_q == crc_rec[15:8], "R4 crc high byte", {8'h0, data_q}, {8'h0, crc_rec[15:8]});
    chk(status[4] == 1'b0, "R4 zero residue", {15'h0, status[4]}, 16'h0);
    rdata();

    // R8 and R7: control write clears irq only; data read clears both
    arm(8'h80);
    sbit(1'b1);
    sbyte(8'h5A);
    chk(irq == 1'b1, "R5 irq raised", {15'h0, irq}, 16'h1);
    wctl(8'hC4);
    chk(irq == 1'b0 && status[1] == 1'b1, "R8 ctrl write", {14'h0, irq, status[1]}, 16'h1);
    rdata();
    chk(status[1] == 1'b0, "R7 data read clears", {15'h0, status[1]}, 16'h0);

    // R11: byte completion coincides with a status read
    arm(8'h80);
    sbit(1'b1);
    for (int i = 0; i < 7; i++) sbit(1'b0);
    @(negedge clk); bit_valid = 1'b1; bit_data = 1'b1; stat_rd = 1'b1;
    @(negedge clk); bit_valid = 1'b0; stat_rd = 1'b0;
    chk(status[1] == 1'b1 && irq == 1'b1 && data_q == 8'h80, "R11 set wins",
        {6'h0, status[1], irq, data_q}, 16'h0380);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule